// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block models the command front end of a parallel NOR flash device. It watches bus write cycles on an asynchronous interface: chip select, write strobe, output enable, byte/word select, address and data. It brings these signals into the clock domain and recognises the multi-cycle unlock sequences that select read-array, reset, identification readout, program, a bypass program mode, whole-chip erase and single-sector erase. When a sequence completes, it sends a one-cycle start pulse to a separate operation engine, together with the latched target address, data and width. The engine signals completion with a done pulse.

The command register has no address of its own. A write that does not fit the expected step of a sequence returns the decoder to read-array mode. Reads pass array data through. In identification mode, reads return fixed codes and a per-sector protect flag instead. In byte mode the top data pin becomes the lowest address bit.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read-array mode. `rdata_o` equals `array_rdata_i` in word mode (`byte_ni`=1). In byte mode it is `{8'h00, array_rdata_i[15:8]}` when `dq_i[15]`=1 and `{8'h00, array_rdata_i[7:0]}` when `dq_i[15]`=0.
- R2: A write cycle is taken when the synchronised `we_ni` rises while the synchronised `ce_ni` is low. A write with `ce_ni` high has no effect.
- R3: The unlock prefix has three steps. First 8'hAA is written to the first unlock address, then 8'h55 to the second, then a command byte to the first. In word mode the unlock addresses are 11'h555 and 11'h2AA, compared on `addr_i[10:0]`. Higher address bits are ignored. Command bytes are compared on data bits 7:0.
- R4: The prefix with command 8'hA0, followed by one write of address/data, gives exactly one `prog_start_o`. `op_addr_o` is `{addr_i,1'b0}` and `op_data_o` is the written word.
- R5: A write that does not match the expected step of a sequence returns the decoder to read-array mode and starts nothing.
- R6: The prefix with command 8'h90 enters identification mode. Reads at `addr_i[1:0]`=0 return `MFR_CODE`, at 1 return `DEV_CODE`, and at 2 return `prot_i[addr_i[ADDR_W-1 -: SECT_W]]` in bit 0. Other offsets return zero. A write of 8'hF0 to any address leaves the mode.
- R7: The prefix with 8'h80, then 8'hAA to the first unlock address, then 8'h55 to the second, then 8'h10 to the first, pulses `chip_erase_start_o`.
- R8: The same five steps followed by 8'h30 at any address pulse `sector_erase_start_o`. `op_addr_o` holds that write's address, so the sector index sits in its top `SECT_W` bits.
- R9: A write of 8'hF0 (or any other non-matching write) between the erase setup steps aborts the erase, and no start is issued.
- R10: After an erase start, every write is ignored, including 8'hF0, until `op_done_i` pulses. The decoder then returns to read-array mode.
- R11: After a program start, writes are ignored until `op_done_i`. The decoder then returns to the mode the program came from.
- R12: The prefix with command 8'h20 enters bypass mode. There, 8'hA0 at any address followed by one address/data write starts a program. The decoder stays in bypass afterwards. 8'h90 followed by 8'h00 leaves bypass for read-array mode.
- R13: In byte mode (`byte_ni`=0) `dq_i[15]` is the lowest byte-address bit. The unlock addresses become byte addresses 12'hAAA and 12'h555, formed from `{addr_i[10:0],dq_i[15]}`. A program latches `op_addr_o`=`{addr_i,dq_i[15]}`, `op_data_o`=`{8'h00,dq_i[7:0]}` and `op_byte_o`=1.
- R14: Each start output is high for a single cycle, at most one start output is high at a time, and no start occurs while an operation is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low; data taken on its rising edge |
| oe_ni | input | 1 | Output enable, active low |
| byte_ni | input | 1 | 0 = byte mode, 1 = word mode |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 16 | Write data; bit 15 is the low address bit in byte mode |
| array_rdata_i | input | 16 | Word read from the array at `addr_i` |
| prot_i | input | 2**SECT_W | Protect flag per sector |
| op_done_i | input | 1 | Completion pulse from the operation engine |
| rd_en_o | output | 1 | Read drive enable (`ce_ni` and `oe_ni` low, `we_ni` high) |
| rdata_o | output | 16 | Read data |
| prog_start_o | output | 1 | Program start pulse |
| chip_erase_start_o | output | 1 | Chip erase start pulse |
| sector_erase_start_o | output | 1 | Sector erase start pulse |
| op_addr_o | output | ADDR_W+1 | Latched byte address of the operation |
| op_data_o | output | 16 | Latched program data |
| op_byte_o | output | 1 | Latched byte-mode flag |

## Verification
The bench builds the block with its defaults:
- `ADDR_W`=19 gives a full-width address, so random upper address bits show that unlock matching uses only the low eleven bits (twelve in byte mode).
- `SECT_W`=4 gives sixteen protect flags, so the identification readout can be compared between a protected and an unprotected sector.
- `SYNC_STAGES`=2 adds a realistic two-stage input delay, so the write strobe, address and data must all be captured in the same cycle.

Random word and byte programs are interleaved with non-matching noise writes. Directed cases cover aborted and ignored sequences.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_C1,
    ST_C2,
    ST_AUTO,
    ST_PGM,
    ST_E1,
    ST_E2,
    ST_E3,
    ST_EBUSY,
    ST_PBUSY,
    ST_BYP,
    ST_BYP_PGM,
    ST_BYP_EXIT
  } cmd_state_e;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_BYP_END = 8'h00;

  localparam logic [10:0] KEY_W_ADDR1 = 11'h555;
  localparam logic [10:0] KEY_W_ADDR2 = 11'h2AA;
  localparam logic [11:0] KEY_B_ADDR1 = 12'hAAA;
  localparam logic [11:0] KEY_B_ADDR2 = 12'h555;

endpackage

// File: rtl/nor_bus_sync.sv
module nor_bus_sync
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              byte_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       dq_i,
  output logic              wr_evt_o,
  output logic [ADDR_W:0]   wr_baddr_o,
  output logic [15:0]       wr_data_o,
  output logic              wr_byte_o,
  output logic              key1_hit_o,
  output logic              key2_hit_o
);

  localparam int BW = ADDR_W + 19;
  localparam logic [BW-1:0] IDLE_BUS = {3'b111, {(ADDR_W + 16){1'b0}}};

  // whole bus travels through the same stages so strobe and payload stay aligned
  logic [SYNC_STAGES-1:0][BW-1:0] pipe_q;
  logic [BW-1:0]                  bus_s;
  logic                           we_prev_q;

  logic              s_ce_n, s_we_n, s_byte_n;
  logic [ADDR_W-1:0] s_addr;
  logic [15:0]       s_dq;
  logic [11:0]       low_baddr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q    <= {SYNC_STAGES{IDLE_BUS}};
      we_prev_q <= 1'b1;
    end else begin
      pipe_q[0] <= {ce_ni, we_ni, byte_ni, addr_i, dq_i};
      for (int s = 1; s < SYNC_STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      we_prev_q <= s_we_n;
    end
  end

  assign bus_s = pipe_q[SYNC_STAGES-1];
  assign {s_ce_n, s_we_n, s_byte_n, s_addr, s_dq} = bus_s;

  assign wr_evt_o  = s_we_n && !we_prev_q && !s_ce_n;
  assign wr_byte_o = !s_byte_n;

  generate
    if (ADDR_W >= 11) begin : g_key
      assign low_baddr = {s_addr[10:0], s_dq[15]};
    end else begin : g_key_narrow
      assign low_baddr = 12'({s_addr, s_dq[15]});
    end
  endgenerate

  always_comb begin
    if (wr_byte_o) begin
      wr_baddr_o = {s_addr, s_dq[15]};
      wr_data_o  = {8'h00, s_dq[7:0]};
      key1_hit_o = (low_baddr == KEY_B_ADDR1);
      key2_hit_o = (low_baddr == KEY_B_ADDR2);
    end else begin
      wr_baddr_o = {s_addr, 1'b0};
      wr_data_o  = s_dq;
      key1_hit_o = (low_baddr[11:1] == KEY_W_ADDR1);
      key2_hit_o = (low_baddr[11:1] == KEY_W_ADDR2);
    end
  end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_evt_i,
  input  logic [ADDR_W:0] wr_baddr_i,
  input  logic [15:0]     wr_data_i,
  input  logic            wr_byte_i,
  input  logic            key1_hit_i,
  input  logic            key2_hit_i,
  input  logic            op_done_i,
  output logic            ident_mode_o,
  output logic            prog_start_o,
  output logic            chip_erase_start_o,
  output logic            sector_erase_start_o,
  output logic [ADDR_W:0] op_addr_o,
  output logic [15:0]     op_data_o,
  output logic            op_byte_o
);

  cmd_state_e st_q, st_d;
  logic       byp_q, byp_d;
  logic       go_prog, go_chip, go_sect, capture;
  logic [7:0] cmd;

  assign cmd = wr_data_i[7:0];

  always_comb begin
    st_d    = st_q;
    byp_d   = byp_q;
    go_prog = 1'b0;
    go_chip = 1'b0;
    go_sect = 1'b0;
    capture = 1'b0;
    if (wr_evt_i) begin
      case (st_q)
        ST_READ: if (key1_hit_i && cmd == CMD_KEY_A) st_d = ST_C1;
        ST_C1:   st_d = (key2_hit_i && cmd == CMD_KEY_B) ? ST_C2 : ST_READ;
        ST_C2: begin
          st_d = ST_READ;
          if (key1_hit_i) begin
            case (cmd)
              CMD_IDENT:  st_d = ST_AUTO;
              CMD_PROG:   st_d = ST_PGM;
              CMD_BYPASS: st_d = ST_BYP;
              CMD_ERASE:  st_d = ST_E1;
              default:    st_d = ST_READ;
            endcase
          end
        end
        ST_AUTO: if (cmd == CMD_RESET) st_d = ST_READ;
        ST_PGM: begin
          go_prog = 1'b1;
          capture = 1'b1;
          byp_d   = 1'b0;
          st_d    = ST_PBUSY;
        end
        ST_E1: st_d = (key1_hit_i && cmd == CMD_KEY_A) ? ST_E2 : ST_READ;
        ST_E2: st_d = (key2_hit_i && cmd == CMD_KEY_B) ? ST_E3 : ST_READ;
        ST_E3: begin
          if (key1_hit_i && cmd == CMD_CHIP) begin
            go_chip = 1'b1;
            capture = 1'b1;
            st_d    = ST_EBUSY;
          end else if (cmd == CMD_SECTOR) begin
            go_sect = 1'b1;
            capture = 1'b1;
            st_d    = ST_EBUSY;
          end else begin
            st_d = ST_READ;
          end
        end
        ST_BYP: begin
          if (cmd == CMD_PROG)       st_d = ST_BYP_PGM;
          else if (cmd == CMD_IDENT) st_d = ST_BYP_EXIT;
        end
        ST_BYP_PGM: begin
          go_prog = 1'b1;
          capture = 1'b1;
          byp_d   = 1'b1;
          st_d    = ST_PBUSY;
        end
        ST_BYP_EXIT: st_d = (cmd == CMD_BYP_END) ? ST_READ : ST_BYP;
        default: st_d = st_q;
      endcase
    end
    // busy states ignore writes; only completion moves them
    if (op_done_i) begin
      if (st_q == ST_EBUSY)      st_d = ST_READ;
      else if (st_q == ST_PBUSY) st_d = byp_q ? ST_BYP : ST_READ;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q                 <= ST_READ;
      byp_q                <= 1'b0;
      prog_start_o         <= 1'b0;
      chip_erase_start_o   <= 1'b0;
      sector_erase_start_o <= 1'b0;
      op_addr_o            <= '0;
      op_data_o            <= '0;
      op_byte_o            <= 1'b0;
    end else begin
      st_q                 <= st_d;
      byp_q                <= byp_d;
      prog_start_o         <= go_prog;
      chip_erase_start_o   <= go_chip;
      sector_erase_start_o <= go_sect;
      if (capture) begin
        op_addr_o <= wr_baddr_i;
        op_data_o <= wr_data_i;
        op_byte_o <= wr_byte_i;
      end
    end
  end

  assign ident_mode_o = (st_q == ST_AUTO);

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux #(
  parameter int          ADDR_W   = 19,
  parameter int          SECT_W   = 4,
  parameter logic [7:0]  MFR_CODE = 8'h5A,
  parameter logic [15:0] DEV_CODE = 16'h22C4
) (
  input  logic                 ident_mode_i,
  input  logic                 byte_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 addr_lsb_i,
  input  logic [15:0]          array_rdata_i,
  input  logic [2**SECT_W-1:0] prot_i,
  output logic [15:0]          rdata_o
);

  localparam int NSECT = 2 ** SECT_W;

  logic [SECT_W-1:0] sect;
  logic [15:0]       word_sel;

  assign sect = addr_i[ADDR_W-1 -: SECT_W];

  always_comb begin
    if (ident_mode_i) begin
      case (addr_i[1:0])
        2'd0:    word_sel = {8'h00, MFR_CODE};
        2'd1:    word_sel = DEV_CODE;
        2'd2:    word_sel = {15'h0, prot_i[sect]};
        default: word_sel = 16'h0;
      endcase
    end else begin
      word_sel = array_rdata_i;
    end
  end

  always_comb begin
    if (byte_ni) rdata_o = word_sel;
    else if (addr_lsb_i && !ident_mode_i) rdata_o = {8'h00, word_sel[15:8]};
    else rdata_o = {8'h00, word_sel[7:0]};
  end

  initial begin
    if (NSECT < 2) $error("SECT_W too small");
  end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int          ADDR_W      = 19,
  parameter int          SECT_W      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  MFR_CODE    = 8'h5A,
  parameter logic [15:0] DEV_CODE    = 16'h22C4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  input  logic                 byte_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [15:0]          dq_i,
  input  logic [15:0]          array_rdata_i,
  input  logic [2**SECT_W-1:0] prot_i,
  input  logic                 op_done_i,
  output logic                 rd_en_o,
  output logic [15:0]          rdata_o,
  output logic                 prog_start_o,
  output logic                 chip_erase_start_o,
  output logic                 sector_erase_start_o,
  output logic [ADDR_W:0]      op_addr_o,
  output logic [15:0]          op_data_o,
  output logic                 op_byte_o
);

  logic            wr_evt, wr_byte, key1_hit, key2_hit, ident_mode;
  logic [ADDR_W:0] wr_baddr;
  logic [15:0]     wr_data;

  nor_bus_sync #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .byte_ni   (byte_ni),
    .addr_i    (addr_i),
    .dq_i      (dq_i),
    .wr_evt_o  (wr_evt),
    .wr_baddr_o(wr_baddr),
    .wr_data_o (wr_data),
    .wr_byte_o (wr_byte),
    .key1_hit_o(key1_hit),
    .key2_hit_o(key2_hit)
  );

  nor_cmd_fsm #(
    .ADDR_W(ADDR_W)
  ) u_fsm (
    .clk_i               (clk_i),
    .rst_ni              (rst_ni),
    .wr_evt_i            (wr_evt),
    .wr_baddr_i          (wr_baddr),
    .wr_data_i           (wr_data),
    .wr_byte_i           (wr_byte),
    .key1_hit_i          (key1_hit),
    .key2_hit_i          (key2_hit),
    .op_done_i           (op_done_i),
    .ident_mode_o        (ident_mode),
    .prog_start_o        (prog_start_o),
    .chip_erase_start_o  (chip_erase_start_o),
    .sector_erase_start_o(sector_erase_start_o),
    .op_addr_o           (op_addr_o),
    .op_data_o           (op_data_o),
    .op_byte_o           (op_byte_o)
  );

  nor_read_mux #(
    .ADDR_W  (ADDR_W),
    .SECT_W  (SECT_W),
    .MFR_CODE(MFR_CODE),
    .DEV_CODE(DEV_CODE)
  ) u_rd (
    .ident_mode_i (ident_mode),
    .byte_ni      (byte_ni),
    .addr_i       (addr_i),
    .addr_lsb_i   (dq_i[15]),
    .array_rdata_i(array_rdata_i),
    .prot_i       (prot_i),
    .rdata_o      (rdata_o)
  );

  assign rd_en_o = !ce_ni && !oe_ni && we_ni;

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
  parameter int ADDR_W = 19
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            op_done_i,
  input logic            prog_start_o,
  input logic            chip_erase_start_o,
  input logic            sector_erase_start_o,
  input logic [ADDR_W:0] op_addr_o,
  input logic [15:0]     op_data_o,
  input logic            op_byte_o
);

  logic any_start, busy_q;

  assign any_start = prog_start_o | chip_erase_start_o | sector_erase_start_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_q <= 1'b0;
    else if (op_done_i) busy_q <= 1'b0;
    else if (any_start) busy_q <= 1'b1;
  end

  // R14
  start_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, chip_erase_start_o, sector_erase_start_o}));

  // R14
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_start |=> !any_start);

  // R10 R11 R14
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !any_start);

  // R4
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !op_done_i) |=> ($stable(op_addr_o) && $stable(op_data_o) && $stable(op_byte_o)));

  // R13
  byte_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o && op_byte_o) |-> (op_data_o[15:8] == 8'h00));

  // R4
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o && !op_byte_o) |-> !op_addr_o[0]);

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .op_done_i           (op_done_i),
  .prog_start_o        (prog_start_o),
  .chip_erase_start_o  (chip_erase_start_o),
  .sector_erase_start_o(sector_erase_start_o),
  .op_addr_o           (op_addr_o),
  .op_data_o           (op_data_o),
  .op_byte_o           (op_byte_o)
);

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;

  localparam int CLK_P = 10;
  localparam int AW    = 19;
  localparam logic [7:0]  MFR = 8'h5A;
  localparam logic [15:0] DEV = 16'h22C4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq = '0;
  logic [15:0]   arr;
  logic [15:0]   prot = 16'h0008;
  logic          done = 1'b0;
  logic          rd_en;
  logic [15:0]   rdata;
  logic          p_st, c_st, s_st;
  logic [AW:0]   op_addr;
  logic [15:0]   op_data;
  logic          op_byte;

  int n_chk = 0, n_fail = 0;
  int n_prog = 0, n_chip = 0, n_sect = 0, n_wide = 0;
  logic [AW:0] cap_addr;
  logic [15:0] cap_data;
  logic        cap_byte;
  logic        prev_any = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] stub_word(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h3C96 ^ {a[18:16], 13'h0};
  endfunction

  assign arr = stub_word(addr);

  nor_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .byte_ni(byte_n), .addr_i(addr), .dq_i(dq), .array_rdata_i(arr),
    .prot_i(prot), .op_done_i(done), .rd_en_o(rd_en), .rdata_o(rdata),
    .prog_start_o(p_st), .chip_erase_start_o(c_st),
    .sector_erase_start_o(s_st), .op_addr_o(op_addr), .op_data_o(op_data),
    .op_byte_o(op_byte)
  );

  always @(negedge clk) begin
    if (p_st) begin
      n_prog++;
      cap_addr = op_addr;
      cap_data = op_data;
      cap_byte = op_byte;
    end
    if (c_st) n_chip++;
    if (s_st) begin
      n_sect++;
      cap_addr = op_addr;
    end
    if ((p_st || c_st || s_st) && prev_any) n_wide++;
    if ((32'(p_st) + 32'(c_st) + 32'(s_st)) > 1) n_wide++;
    prev_any = p_st || c_st || s_st;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic sel = 1'b0);
    @(negedge clk);
    addr = a; dq = d; ce_n = sel;
    @(negedge clk);
    we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bwr(input logic [AW:0] ba, input logic [7:0] d);
    wr(ba[AW:1], {ba[0], 7'h0, d});
  endtask

  task automatic prefix(input logic [7:0] c);
    wr(19'h555, 16'h00AA);
    wr(19'h2AA, 16'h0055);
    wr(19'h555, {8'h00, c});
  endtask

  task automatic bprefix(input logic [7:0] c);
    bwr(20'hAAA, 8'hAA);
    bwr(20'h555, 8'h55);
    bwr(20'hAAA, c);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic lsb, output logic [15:0] v);
    @(negedge clk);
    addr = a; dq = {lsb, 15'h0}; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    v = rdata;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_byte(input logic b);
    @(negedge clk); byte_n = b;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_array(input logic [AW-1:0] a, input logic bm, input logic lsb);
    logic [15:0] w = stub_word(a);
    if (!bm) return w;
    return lsb ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  initial begin
    logic [15:0] v;
    int base;
    void'($urandom(32'h1D2C));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 reset no start", 32'(p_st | c_st | s_st), 0);
    rd(19'h1234, 1'b0, v); check("R1 read word", 32'(v), 32'(exp_array(19'h1234, 0, 0)));
    set_byte(1'b0);
    rd(19'h4321, 1'b1, v); check("R1 read byte hi", 32'(v), 32'(exp_array(19'h4321, 1, 1)));
    rd(19'h4321, 1'b0, v); check("R1 read byte lo", 32'(v), 32'(exp_array(19'h4321, 1, 0)));
    set_byte(1'b1);

    // R4 R3 word program, upper address bits ignored on unlock
    wr(19'h7D555, 16'h00AA); wr(19'h402AA, 16'h1255); wr(19'h01555, 16'h00A0);
    wr(19'h2BEEF, 16'hC0DE);
    check("R4 prog count", n_prog, 1);
    check("R4 prog addr", 32'(cap_addr), 32'({19'h2BEEF, 1'b0}));
    check("R4 prog data", 32'(cap_data), 32'h0000C0DE);
    check("R3 prog width", 32'(cap_byte), 0);

    // R11 writes ignored while program busy
    prefix(8'hA0); wr(19'h00100, 16'h1111);
    check("R11 no prog while busy", n_prog, 1);
    pulse_done();
    prefix(8'hA0); wr(19'h00200, 16'h2222);
    check("R11 prog after done", n_prog, 2);
    pulse_done();

    // R5 mismatch returns to read
    wr(19'h555, 16'h00AA); wr(19'h2AB, 16'h0055); wr(19'h555, 16'h00A0); wr(19'h00300, 16'h3333);
    check("R5 mismatch no prog", n_prog, 2);
    wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055); wr(19'h555, 16'h0077); wr(19'h00300, 16'h3333);
    check("R5 bad cmd no prog", n_prog, 2);

    // R2 write with CE high ignored
    wr(19'h555, 16'h00AA, 1'b1); wr(19'h2AA, 16'h0055, 1'b1);
    wr(19'h555, 16'h00A0, 1'b1); wr(19'h00400, 16'h4444, 1'b1);
    check("R2 ce high no prog", n_prog, 2);
    rd(19'h0, 1'b0, v); check("R2 still array", 32'(v), 32'(stub_word(19'h0)));

    // R6 identification
    prefix(8'h90);
    rd(19'h00000, 1'b0, v); check("R6 mfr", 32'(v), 32'(MFR));
    rd(19'h00001, 1'b0, v); check("R6 dev", 32'(v), 32'(DEV));
    rd({4'd3, 15'h2}, 1'b0, v); check("R6 prot set", 32'(v), 1);
    rd({4'd5, 15'h2}, 1'b0, v); check("R6 prot clr", 32'(v), 0);
    rd(19'h00003, 1'b0, v); check("R6 other offs", 32'(v), 0);
    set_byte(1'b0);
    rd(19'h00001, 1'b1, v); check("R13 byte dev", 32'(v), 32'(DEV[7:0]));
    set_byte(1'b1);
    wr(19'h12345, 16'h00F0);
    rd(19'h00000, 1'b0, v); check("R6 exit", 32'(v), 32'(stub_word(19'h0)));

    // R7 chip erase
    prefix(8'h80); wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055); wr(19'h555, 16'h0010);
    check("R7 chip start", n_chip, 1);
    pulse_done();

    // R8 R10 sector erase, then everything ignored until done
    prefix(8'h80); wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055); wr({4'd9, 15'h0123}, 16'h0030);
    check("R8 sect start", n_sect, 1);
    check("R8 sect addr", 32'(cap_addr[AW -: 4]), 9);
    wr(19'h0, 16'h00F0);
    prefix(8'h90);
    prefix(8'hA0); wr(19'h00500, 16'h5555);
    check("R10 no prog in erase", n_prog, 2);
    pulse_done();
    rd(19'h00000, 1'b0, v); check("R10 read after erase", 32'(v), 32'(stub_word(19'h0)));

    // R9 reset between erase steps
    prefix(8'h80); wr(19'h555, 16'h00AA); wr(19'h0, 16'h00F0);
    wr(19'h2AA, 16'h0055); wr(19'h555, 16'h0010);
    check("R9 abort chip", n_chip, 1);
    prefix(8'h80); wr(19'h555, 16'h00F0); wr(19'h555, 16'h00AA); wr(19'h2AA, 16'h0055);
    wr(19'h40000, 16'h0030);
    check("R9 abort sect", n_sect, 1);

    // R12 bypass
    prefix(8'h20);
    wr(19'h00000, 16'h00A0); wr(19'h00600, 16'h6666);
    check("R12 byp prog", n_prog, 3);
    check("R12 byp data", 32'(cap_data), 32'h6666);
    pulse_done();
    wr(19'h07777, 16'h00A0); wr(19'h00700, 16'h7777);
    check("R12 stays bypass", n_prog, 4);
    pulse_done();
    wr(19'h00000, 16'h0090); wr(19'h00000, 16'h0000);
    wr(19'h01234, 16'h00A0); wr(19'h00800, 16'h8888);
    check("R12 bypass exit", n_prog, 4);

    // R13 byte mode program
    set_byte(1'b0);
    bprefix(8'hA0); bwr(20'h3ABCD, 8'h5E);
    check("R13 byte prog", n_prog, 5);
    check("R13 byte addr", 32'(cap_addr), 32'h3ABCD);
    check("R13 byte data", 32'(cap_data), 32'h5E);
    check("R13 byte flag", 32'(cap_byte), 1);
    pulse_done();
    bwr(20'hAAA, 8'hAA); bwr(20'hAAB, 8'h55); bwr(20'hAAA, 8'hA0); bwr(20'h00010, 8'h01);
    check("R13 byte bad key", n_prog, 5);
    set_byte(1'b1);

    // R4 R13 random programs mixed with noise writes
    for (int i = 0; i < 30; i++) begin
      logic bm = $urandom_range(1, 0) == 1;
      logic [AW:0] ba = AW'($urandom) * 2 + 20'($urandom_range(1, 0));
      logic [15:0] d = 16'($urandom);
      logic [AW:0] ea;
      logic [15:0] ed;
      base = n_prog;
      set_byte(!bm);
      wr(AW'($urandom), {8'($urandom), 8'h3C});
      if (bm) begin
        bprefix(8'hA0); bwr(ba, d[7:0]);
        ea = ba; ed = {8'h00, d[7:0]};
      end else begin
        prefix(8'hA0); wr(ba[AW:1], d);
        ea = {ba[AW:1], 1'b0}; ed = d;
      end
      check("R4 rand count", n_prog, base + 1);
      check("R4 rand addr", 32'(cap_addr), 32'(ea));
      check("R13 rand data", 32'(cap_data), 32'(ed));
      check("R13 rand flag", 32'(cap_byte), 32'(bm));
      pulse_done();
    end
    set_byte(1'b1);

    // R14 pulse width and exclusivity
    check("R14 single pulses", n_wide, 0);
    check("R14 read enable", 32'(rd_en), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R14 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule